// File: doc/BRIEF.md
# Dynamic Pixel-Pair Hit Formatter

This block sits at the end of one double column of a pixel readout array. Triggered hits arrive one per handshake as protected words, sorted by column and then by row. Each word is first checked and repaired by a single-error-correct, double-error-detect code. The repaired hit is then either held back to wait for a vertical neighbour or packed into a fixed 24-bit record. When a hit's partner sits in the row directly above it in the same column, the two hits leave as one record. Pair boundaries follow the hits that actually arrive, so a pair may start on any row.

The pairing engine is a three-state machine. In S_EMPTY no hit is held. An accepted good word without the end flag moves it to S_HOLD (transition T_STORE). An accepted good word with the end flag is emitted alone and the machine stays in S_EMPTY (T_SOLO_LAST).

In S_HOLD, a good adjacent word completes a pair and returns the machine to S_EMPTY (T_PAIR). A good non-adjacent word emits the held hit alone and takes its place. Without the end flag this is T_REPLACE, back to S_HOLD. With the end flag it is T_REPLACE_LAST, to S_FLUSH. A double-error word carrying the end flag emits the held hit alone and goes to S_EMPTY (T_DROP_FLUSH). A double-error word without the flag leaves S_HOLD unchanged.

S_FLUSH refuses input and emits the held hit alone as soon as the output register is free (T_FLUSH, to S_EMPTY). The output register holds one record and keeps it until the consumer takes it.

Top module: `hit_pair_formatter`

## Requirements
- R1: The input codeword is 26 bits. Bit 0 is even parity over the whole word. Bits 1..25 are Hamming positions, with check bits at positions 1, 2, 4, 8 and 16. Each check bit gives even parity over the positions whose index has that bit set. Data bit j sits at the j-th non-power-of-two position counting upward. The 20 data bits are {column[6:0], row[8:0], ToT[3:0]}, with ToT in data bits 3:0. Any single flipped bit is corrected, including a flip of the parity bit.
- R2: A word with a double-bit error is discarded with no record, and err_flag goes high on the next clock and stays high until reset.
- R3: A record is {column[23:17], row[16:8], lower ToT[7:4], upper ToT[3:0]}. This holds for the full field range, up to column 79 and row 335.
- R4: A good hit in the same column and exactly one row above the held hit merges with it into one record. The row field gives the lower row, and the upper ToT comes from the new hit.
- R5: A hit with no partner (a different column, or a row gap) is emitted with upper ToT 4'hF.
- R6: A hit consumed as the upper member of a pair never pairs again. The hit one row above it is emitted by itself.
- R7: A word with in_last set closes the group, and any hit still held is emitted. If a hit has to be flushed after the current one, in_ready is low for one cycle.
- R8: While out_valid is high and out_ready is low, out_data stays stable, in_ready is low, and no hit is lost.
- R9: After reset, out_valid and err_flag are low and in_ready is high.
- R10: A double-error word carrying in_last still flushes the held hit as a single record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Formatter accepts the input word |
| in_word | input | 26 | Protected hit codeword |
| in_last | input | 1 | Last hit of the current group |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_data | output | 24 | Packed pair record |
| err_flag | output | 1 | Sticky uncorrectable-error flag |

## Verification
Two functions can fall on the same clock edge: discarding an uncorrectable word and flushing the held hit because that same word carries the end flag. The bench provokes this by holding a good hit and then sending a word with two flipped bits and in_last set. It expects exactly one record, the held hit with upper ToT 4'hF, and err_flag high one cycle later. A second case sends an adjacent word while the output register is stalled. The stalled record must be freed and the new pair loaded on the same edge without losing either one.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
    function automatic bit is_pow2(int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int calc_chk(int k);
        for (int r = 0; r < 31; r++)
            if ((1 << r) >= k + r + 1) return r;
        return 31;
    endfunction

    localparam int COL_W  = 7;
    localparam int ROW_W  = 9;
    localparam int TOT_W  = 4;
    localparam int DATA_W = COL_W + ROW_W + TOT_W;
    localparam int REC_W  = COL_W + ROW_W + 2 * TOT_W;
    localparam int CHK_W  = calc_chk(DATA_W);
    localparam int HAM_N  = DATA_W + CHK_W;
    localparam int CW_W   = HAM_N + 1;

    // position of data bit idx inside the Hamming word
    function automatic int data_pos(int idx);
        int n = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (!is_pow2(p)) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [TOT_W-1:0] tot;
    } hit_t;
endpackage

// File: rtl/hpf_secded_dec.sv
module hpf_secded_dec
    import hpf_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output hit_t            hit,
    output logic            dbl
);
    logic [CHK_W-1:0]  syn;
    logic              par;
    logic              syn_ok;
    logic [CW_W-1:0]   cor;
    logic [DATA_W-1:0] d;

    always_comb begin
        syn = '0;
        for (int i = 1; i <= HAM_N; i++)
            for (int k = 0; k < CHK_W; k++)
                if (((i >> k) & 1) == 1) syn[k] = syn[k] ^ cw[i];
        par    = ^cw;
        syn_ok = int'(syn) <= HAM_N;
        cor    = cw;
        if (par && syn_ok) cor[syn] = ~cw[syn];
        dbl    = (!par && (syn != '0)) || (par && !syn_ok);
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_extract
        assign d[j] = cor[data_pos(j)];
    end

    assign hit = hit_t'(d);
endmodule

// File: rtl/hpf_pair_fsm.sv
module hpf_pair_fsm
    import hpf_pkg::*;
#(
    parameter logic [TOT_W-1:0] NO_HIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  hit_t             in_hit,
    input  logic             in_bad,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [REC_W-1:0] out_data,
    output logic             err_flag
);
    typedef enum logic [1:0] {S_EMPTY, S_HOLD, S_FLUSH} st_e;

    st_e              state, nxt;
    hit_t             pend, pend_nxt;
    logic             load, set_err, can_load, accept, adjacent;
    logic [REC_W-1:0] rec;

    function automatic logic [REC_W-1:0] mk_rec(hit_t lo, logic [TOT_W-1:0] hi);
        return {lo.col, lo.row, lo.tot, hi};
    endfunction

    assign can_load = !out_valid || out_ready;
    assign in_ready = can_load && (state != S_FLUSH);
    assign accept   = in_valid && in_ready;
    assign adjacent = (in_hit.col == pend.col) && (in_hit.row == pend.row + 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        pend_nxt = pend;
        load     = 1'b0;
        set_err  = 1'b0;
        rec      = '0;
        unique case (state)
            S_EMPTY: if (accept) begin
                if (in_bad) set_err = 1'b1;
                else if (in_last) begin
                    load = 1'b1;
                    rec  = mk_rec(in_hit, NO_HIT);
                end else begin
                    pend_nxt = in_hit;
                    nxt      = S_HOLD;
                end
            end
            S_HOLD: if (accept) begin
                if (in_bad) begin
                    set_err = 1'b1;
                    if (in_last) begin
                        load = 1'b1;
                        rec  = mk_rec(pend, NO_HIT);
                        nxt  = S_EMPTY;
                    end
                end else if (adjacent) begin
                    load = 1'b1;
                    rec  = mk_rec(pend, in_hit.tot);
                    nxt  = S_EMPTY;
                end else begin
                    load     = 1'b1;
                    rec      = mk_rec(pend, NO_HIT);
                    pend_nxt = in_hit;
                    nxt      = in_last ? S_FLUSH : S_HOLD;
                end
            end
            S_FLUSH: if (can_load) begin
                load = 1'b1;
                rec  = mk_rec(pend, NO_HIT);
                nxt  = S_EMPTY;
            end
            default: nxt = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            err_flag  <= 1'b0;
        end else begin
            pend <= pend_nxt;
            if (load) begin
                out_valid <= 1'b1;
                out_data  <= rec;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (set_err) err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/hit_pair_formatter.sv
module hit_pair_formatter
    import hpf_pkg::*;
#(
    parameter logic [TOT_W-1:0] NO_HIT_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CW_W-1:0]  in_word,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REC_W-1:0] out_data,
    output logic             err_flag
);
    hit_t dec_hit;
    logic dec_dbl;

    hpf_secded_dec u_dec (
        .cw  (in_word),
        .hit (dec_hit),
        .dbl (dec_dbl)
    );

    hpf_pair_fsm #(.NO_HIT(NO_HIT_CODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_hit    (dec_hit),
        .in_bad    (dec_dbl),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .err_flag  (err_flag)
    );
endmodule

// File: rtl/hpf_checker.sv
module hpf_checker
    import hpf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [REC_W-1:0] out_data,
    input logic             err_flag,
    input logic             dec_dbl
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R2
    AST_DBL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && dec_dbl |=> err_flag); // R2
endmodule

bind hit_pair_formatter hpf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .err_flag  (err_flag),
    .dec_dbl   (dec_dbl)
);

// File: tb/hit_pair_formatter_test.sv
`timescale 1ns/1ps
module hit_pair_formatter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [25:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_data;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int n_got  = 0;
    logic [23:0] got [0:31];

    always #2.5 clk = ~clk;

    hit_pair_formatter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .err_flag(err_flag)
    );

    // entry: col[47:41] row[40:32] tot[31:28] last[27] flip[26:1] err_after[0]
    localparam logic [47:0] VEC [19] = '{
        {7'd3,  9'd10,  4'd5,  1'b0, 26'h0,   1'b0},
        {7'd3,  9'd11,  4'd7,  1'b0, 26'h0,   1'b0},
        {7'd3,  9'd12,  4'd2,  1'b0, 26'h0,   1'b0},
        {7'd3,  9'd14,  4'd9,  1'b0, 26'h80,  1'b0},
        {7'd4,  9'd15,  4'd1,  1'b1, 26'h0,   1'b0},
        {7'd5,  9'd0,   4'd3,  1'b0, 26'h0,   1'b0},
        {7'd5,  9'd1,   4'd4,  1'b1, 26'h1,   1'b0},
        {7'd79, 9'd335, 4'd14, 1'b1, 26'h0,   1'b0},
        {7'd6,  9'd20,  4'd6,  1'b0, 26'h0,   1'b0},
        {7'd6,  9'd21,  4'd8,  1'b0, 26'h208, 1'b1},
        {7'd6,  9'd22,  4'd10, 1'b0, 26'h0,   1'b1},
        {7'd6,  9'd23,  4'd11, 1'b1, 26'h0,   1'b1},
        {7'd7,  9'd1,   4'd2,  1'b0, 26'h0,   1'b1},
        {7'd7,  9'd2,   4'd3,  1'b0, 26'h0,   1'b1},
        {7'd7,  9'd3,   4'd4,  1'b1, 26'h0,   1'b1},
        {7'd8,  9'd5,   4'd1,  1'b0, 26'h0,   1'b1},
        {7'd9,  9'd6,   4'd2,  1'b1, 26'h208, 1'b1},
        {7'd10, 9'd7,   4'd0,  1'b0, 26'h0,   1'b1},
        {7'd11, 9'd8,   4'd0,  1'b1, 26'h0,   1'b1}
    };

    localparam logic [23:0] EXP [13] = '{
        {7'd3,  9'd10,  4'd5,  4'd7},
        {7'd3,  9'd12,  4'd2,  4'hF},
        {7'd3,  9'd14,  4'd9,  4'hF},
        {7'd4,  9'd15,  4'd1,  4'hF},
        {7'd5,  9'd0,   4'd3,  4'd4},
        {7'd79, 9'd335, 4'd14, 4'hF},
        {7'd6,  9'd20,  4'd6,  4'hF},
        {7'd6,  9'd22,  4'd10, 4'd11},
        {7'd7,  9'd1,   4'd2,  4'd3},
        {7'd7,  9'd3,   4'd4,  4'hF},
        {7'd8,  9'd5,   4'd1,  4'hF},
        {7'd10, 9'd7,   4'd0,  4'hF},
        {7'd11, 9'd8,   4'd0,  4'hF}
    };

    string exp_tag [13] = '{"R4", "R5", "R1", "R7", "R1", "R3", "R2",
                            "R4", "R4", "R6", "R10", "R5", "R7"};

    function automatic logic [25:0] enc(logic [6:0] c, logic [8:0] r, logic [3:0] t);
        logic [19:0] d = {c, r, t};
        logic [25:0] w = '0;
        int j = 0;
        for (int p = 1; p < 26; p++)
            if ((p & (p - 1)) != 0) begin
                w[p] = d[j];
                j++;
            end
        for (int k = 0; k < 5; k++)
            for (int p = 1; p < 26; p++)
                if (((p >> k) & 1) == 1 && p != (1 << k)) w[1 << k] = w[1 << k] ^ w[p];
        w[0] = ^w[25:1];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [25:0] w, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready && n_got < 32) begin
            got[n_got] = out_data;
            n_got++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid, "R9", 32'(out_valid), 0);
        check(!err_flag,  "R9", 32'(err_flag), 0);
        check(in_ready,   "R9", 32'(in_ready), 1);

        out_ready = 1'b1;
        for (int i = 0; i < 19; i++) begin
            send(enc(VEC[i][47:41], VEC[i][40:32], VEC[i][31:28]) ^ VEC[i][26:1], VEC[i][27]);
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check(err_flag == VEC[i][0], "R2", 32'(err_flag), 32'(VEC[i][0]));
        end
        repeat (5) @(negedge clk);
        check(n_got == 13, "R4", 32'(n_got), 13);
        for (int i = 0; i < 13; i++)
            check(got[i] == EXP[i], exp_tag[i], 32'(got[i]), 32'(EXP[i]));

        // R8 stall with pending input
        @(negedge clk);
        out_ready = 1'b0;
        send(enc(7'd20, 9'd30, 4'd1), 1'b0);
        send(enc(7'd20, 9'd32, 4'd2), 1'b0);
        @(negedge clk);
        in_word = enc(7'd20, 9'd33, 4'd3);
        in_last = 1'b1;
        for (int c = 0; c < 4; c++) begin
            #1;
            check(!in_ready, "R8", 32'(in_ready), 0);
            check(out_valid, "R8", 32'(out_valid), 1);
            check(out_data == {7'd20, 9'd30, 4'd1, 4'hF}, "R8", 32'(out_data),
                  32'({7'd20, 9'd30, 4'd1, 4'hF}));
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(n_got == 15, "R8", 32'(n_got), 15);
        check(got[13] == {7'd20, 9'd30, 4'd1, 4'hF}, "R8", 32'(got[13]),
              32'({7'd20, 9'd30, 4'd1, 4'hF}));
        check(got[14] == {7'd20, 9'd32, 4'd2, 4'd3}, "R8", 32'(got[14]),
              32'({7'd20, 9'd32, 4'd2, 4'd3}));

        // R9 reset clears the sticky flag
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!err_flag,  "R9", 32'(err_flag), 0);
        check(!out_valid, "R9", 32'(out_valid), 0);
        finish_sim();
    end
endmodule